// File: doc/BRIEF.md
# SPI NOR Generic Command Shifter

This block lets a host run short, arbitrary transactions against a serial NOR flash over a single-bit SPI link. The host writes a small set of byte registers: six program-data bytes, a bit count and a command byte. On a start command the block opens one chip-select frame and shifts out the count's worth of bits. The opcode goes first, from the highest-numbered program-data byte, and the bits walk down toward byte 0, each byte MSB first. The bits returned on MISO are stored in six capture bytes. A received byte lands in the capture byte whose index matches the program-data slot that was on the wire at that time.

Two shortcut commands read and write the flash status register without the host building the frame itself. The block accepts no command at all until a fixed key has been written to a gate register. The host learns that a transfer has finished by reading the command register until it returns zero.

Register map (byte addresses): 0x00 command, 0x01 bit count, 0x02 status byte (read only), 0x03 gate, 0x08+n program-data byte n, 0x10+n capture byte n (read only), for n = 0..5.

Top module: `nor_cmd_shifter`

## Requirements
- R1: After reset, spiCsN is 1 and spiSck is 0, and the command register and the status byte read 0x00.
- R2: Command writes have no effect until 0x30 has been written to the gate register at 0x03. Any other value written to the gate locks the block again.
- R3: Writing 0x04 to the command register starts a generic frame. The frame shifts out the 48-bit vector {pd5,pd4,pd3,pd2,pd1,pd0}, most significant bit first, for as many bits as the count register at 0x01 gives.
- R4: In a generic frame, the k-th received bit (k from 0) is stored in bit 47-k of {cap5,...,cap0}. So the byte received during the slot of pd n ends up in capture byte n. All capture bytes are cleared when a generic frame starts.
- R5: A count of 0 sends no frame, and the command still clears. A count above 48 is clamped to 48 bits.
- R6: While a frame is in progress the command register reads back the code that started it. It reads 0x00 again from the cycle in which spiCsN returns high.
- R7: SPI mode 0 is used. spiSck idles low and toggles only while spiCsN is low. spiMosi changes only while spiSck is low, and spiMiso is sampled on the rising edge of spiSck.
- R8: spiCsN rises two clock cycles (one SCK period) after the last falling edge of spiSck.
- R9: Command 0x02 sends the opcode 0x05 and then receives 8 bits. Those 8 bits go to the status byte at 0x02, and the capture bytes are left unchanged.
- R10: Command 0x20 sends the opcode 0x01 and then pd5, for a 16-bit frame.
- R11: Command writes made while a frame is in progress are ignored. Program-data writes made during a frame take effect only for the next frame.
- R12: A command value other than 0x04, 0x02 or 0x20 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SCK runs at half this rate |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| spiSck | output | 1 | Serial clock to the flash |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
Two events can meet in a single cycle: a host register write and the frame engine's own activity. In one case the host rewrites a program-data byte and issues a second command a few cycles after a frame has started, while the shifter is consuming the snapshot taken at the start. The bench checks that only one chip-select frame appears and that it carries the old byte. The next frame must carry the new byte. A separate check confirms that the busy readback drops in the same cycle that chip select is released.

// File: rtl/nor_shift_pkg.sv
package nor_shift_pkg;

  localparam logic [7:0] CMD_GENERIC = 8'h04;
  localparam logic [7:0] CMD_STAT_RD = 8'h02;
  localparam logic [7:0] CMD_STAT_WR = 8'h20;
  localparam logic [7:0] GATE_KEY    = 8'h30;
  localparam logic [7:0] OP_RDSR     = 8'h05;
  localparam logic [7:0] OP_WRSR     = 8'h01;

  localparam int REG_CMD    = 0;
  localparam int REG_COUNT  = 1;
  localparam int REG_STATUS = 2;
  localparam int REG_GATE   = 3;
  localparam int PD_BASE    = 8;
  localparam int CAP_BASE   = 16;

  typedef enum logic [1:0] {
    XFER_GENERIC,
    XFER_STAT_RD,
    XFER_STAT_WR
  } xfer_kind_e;

  typedef struct packed {
    logic       load;
    logic       shift;
    logic       sample;
    xfer_kind_e kind;
  } shift_strobe_t;

endpackage

// File: rtl/nor_shift_ctrl.sv
module nor_shift_ctrl
  import nor_shift_pkg::*;
#(
  parameter int NBYTES = 6,
  localparam int TB    = NBYTES * 8,
  localparam int CNT_W = $clog2(TB + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic             gateWe,
  input  logic [7:0]       wrData,
  input  logic [7:0]       countReg,
  output shift_strobe_t    strb,
  output logic [CNT_W-1:0] bitCnt,
  output logic             busy,
  output logic [7:0]       activeCmd,
  output logic             unlocked,
  output logic             csN,
  output logic             sck
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD_A, ST_HOLD_B
  } ctrl_state_e;

  ctrl_state_e      state;
  xfer_kind_e       activeKind;
  xfer_kind_e       newKind;
  logic             cmdValid;
  logic             startNow;
  logic [CNT_W-1:0] totalBits;
  logic [CNT_W-1:0] reqBits;

  always_comb begin
    cmdValid = 1'b1;
    newKind  = XFER_GENERIC;
    reqBits  = CNT_W'(16);
    if (wrData == CMD_GENERIC) begin
      if (int'(countReg) > TB) reqBits = CNT_W'(TB);
      else                     reqBits = CNT_W'(countReg);
    end else if (wrData == CMD_STAT_RD) begin
      newKind = XFER_STAT_RD;
    end else if (wrData == CMD_STAT_WR) begin
      newKind = XFER_STAT_WR;
    end else begin
      cmdValid = 1'b0;
    end
  end

  assign startNow = (state == ST_IDLE) && cmdWe && unlocked && cmdValid;

  always_comb begin
    strb.load   = startNow;
    strb.shift  = (state == ST_HIGH);
    strb.sample = (state == ST_HIGH);
    strb.kind   = (state == ST_IDLE) ? newKind : activeKind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      activeKind <= XFER_GENERIC;
      totalBits  <= '0;
      bitCnt     <= '0;
      busy       <= 1'b0;
      activeCmd  <= '0;
      unlocked   <= 1'b0;
      csN        <= 1'b1;
      sck        <= 1'b0;
    end else begin
      if (gateWe) unlocked <= (wrData == GATE_KEY);
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            busy       <= 1'b1;
            activeCmd  <= wrData;
            activeKind <= newKind;
            totalBits  <= reqBits;
            bitCnt     <= '0;
            state      <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (totalBits == '0) begin
            busy      <= 1'b0;
            activeCmd <= '0;
            state     <= ST_IDLE;
          end else begin
            csN   <= 1'b0;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          sck   <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: begin
          sck    <= 1'b0;
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == totalBits - 1'b1) state <= ST_HOLD_A;
          else                            state <= ST_LOW;
        end
        ST_HOLD_A: state <= ST_HOLD_B;
        ST_HOLD_B: begin
          csN       <= 1'b1;
          busy      <= 1'b0;
          activeCmd <= '0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nor_shift_dp.sv
module nor_shift_dp
  import nor_shift_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int ADDR_W = 5,
  localparam int TB    = NBYTES * 8,
  localparam int CNT_W = $clog2(TB + 1),
  localparam int IDX_W = $clog2(TB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  shift_strobe_t     strb,
  input  logic [CNT_W-1:0]  bitIdx,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic [TB-1:0]     progVec,
  output logic [TB-1:0]     capVec,
  output logic [7:0]        countReg,
  output logic [7:0]        statusByte
);

  logic [7:0]      progData [NBYTES];
  logic [TB-1:0]   txSh;
  logic [IDX_W-1:0] capPos;

  for (genvar n = 0; n < NBYTES; n++) begin : g_pack
    assign progVec[n*8 +: 8] = progData[n];
  end

  assign mosiOut = txSh[TB-1];
  assign capPos  = IDX_W'(TB - 1) - IDX_W'(bitIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NBYTES; n++) progData[n] <= '0;
      countReg <= '0;
    end else if (regWrEn) begin
      for (int n = 0; n < NBYTES; n++)
        if (regAddr == ADDR_W'(PD_BASE + n)) progData[n] <= regWrData;
      if (regAddr == ADDR_W'(REG_COUNT)) countReg <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh       <= '0;
      capVec     <= '0;
      statusByte <= '0;
    end else if (strb.load) begin
      case (strb.kind)
        XFER_STAT_RD: txSh <= {OP_RDSR, {(TB-8){1'b0}}};
        XFER_STAT_WR: txSh <= {OP_WRSR, progData[NBYTES-1], {(TB-16){1'b0}}};
        default: begin
          txSh   <= progVec;
          capVec <= '0;
        end
      endcase
    end else begin
      if (strb.shift) txSh <= {txSh[TB-2:0], 1'b0};
      if (strb.sample) begin
        if (strb.kind == XFER_GENERIC)
          capVec[capPos] <= misoIn;
        else if (strb.kind == XFER_STAT_RD && bitIdx >= CNT_W'(8))
          statusByte <= {statusByte[6:0], misoIn};
      end
    end
  end

endmodule

// File: rtl/nor_cmd_shifter.sv
module nor_cmd_shifter
  import nor_shift_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int ADDR_W = 5,
  localparam int TB    = NBYTES * 8,
  localparam int CNT_W = $clog2(TB + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);

  shift_strobe_t    strb;
  logic [CNT_W-1:0] bitCnt;
  logic             busy;
  logic             unlocked;
  logic [7:0]       activeCmd;
  logic [7:0]       countReg;
  logic [7:0]       statusByte;
  logic [TB-1:0]    progVec;
  logic [TB-1:0]    capVec;
  logic             cmdWe;
  logic             gateWe;

  assign cmdWe  = regWrEn && (regAddr == ADDR_W'(REG_CMD));
  assign gateWe = regWrEn && (regAddr == ADDR_W'(REG_GATE));

  nor_shift_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .gateWe(gateWe),
    .wrData(regWrData), .countReg(countReg), .strb(strb), .bitCnt(bitCnt),
    .busy(busy), .activeCmd(activeCmd), .unlocked(unlocked),
    .csN(spiCsN), .sck(spiSck)
  );

  nor_shift_dp #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .bitIdx(bitCnt), .misoIn(spiMiso),
    .mosiOut(spiMosi), .progVec(progVec), .capVec(capVec),
    .countReg(countReg), .statusByte(statusByte)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(REG_CMD))    regRdData = activeCmd;
    if (regAddr == ADDR_W'(REG_COUNT))  regRdData = countReg;
    if (regAddr == ADDR_W'(REG_STATUS)) regRdData = statusByte;
    for (int n = 0; n < NBYTES; n++) begin
      if (regAddr == ADDR_W'(PD_BASE + n))  regRdData = progVec[n*8 +: 8];
      if (regAddr == ADDR_W'(CAP_BASE + n)) regRdData = capVec[n*8 +: 8];
    end
  end

endmodule

// File: rtl/nor_cmd_shifter_chk.sv
module nor_cmd_shifter_chk #(
  parameter int NBYTES = 6,
  localparam int TB    = NBYTES * 8,
  localparam int CNT_W = $clog2(TB + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             spiCsN,
  input logic             spiSck,
  input logic             spiMosi,
  input logic             busy,
  input logic             unlocked,
  input logic [CNT_W-1:0] bitCnt
);

  // R2: a frame can only begin when the gate was open
  a_r2_start_needs_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(unlocked));

  // R6: chip select release coincides with busy clearing
  a_r6_release_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> !busy);

  // R6/R7: idle bus is quiet
  a_r6_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (spiCsN && !spiSck));

  // R7: SCK moves only inside a frame
  a_r7_sck_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiSck) |-> !spiCsN);

  // R7: MOSI holds while SCK is high
  a_r7_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> $stable(spiMosi));

  // R5: bit counter never passes the clamp
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(TB));

endmodule

bind nor_cmd_shifter nor_cmd_shifter_chk #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck),
  .spiMosi(spiMosi), .busy(busy), .unlocked(unlocked), .bitCnt(bitCnt)
);

// File: tb/nor_cmd_shifter_test.sv
`timescale 1ns/1ps
module nor_cmd_shifter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       spiSck, spiCsN, spiMosi;
  logic       spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;

  // slave model state
  logic [63:0] mosiLog = '0;
  logic [47:0] slaveReply = '0;
  int          bitsSeen = 0;
  int          frames = 0;
  int          replyIdx = 0;
  realtime     lastFall = 0;
  realtime     csRise = 0;

  always #5 clk = ~clk;

  nor_cmd_shifter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .spiSck(spiSck),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  always @(negedge spiCsN) begin
    frames++;
    bitsSeen = 0;
    replyIdx = 0;
    spiMiso  = slaveReply[47];
  end
  always @(posedge spiCsN) csRise = $realtime;
  always @(posedge spiSck) if (!spiCsN) begin
    mosiLog = {mosiLog[62:0], spiMosi};
    bitsSeen++;
  end
  always @(negedge spiSck) if (!spiCsN) begin
    lastFall = $realtime;
    replyIdx++;
    if (replyIdx < 48) spiMiso = slaveReply[47 - replyIdx];
  end

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 400; i++) begin
      rdReg(5'h00, v);
      if (v == 8'h00) break;
    end
  endtask

  task automatic setPd(input logic [47:0] v);
    for (int n = 0; n < 6; n++) wrReg(5'(8 + n), v[n*8 +: 8]);
  endtask

  task automatic checkCaps(input logic [47:0] exp, input string req);
    logic [7:0] v;
    for (int n = 0; n < 6; n++) begin
      rdReg(5'(16 + n), v);
      check(v == exp[n*8 +: 8], req, 64'(v), 64'(exp[n*8 +: 8]));
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rdReg(5'h00, v);
    check(v == 8'h00, "R1 cmd", 64'(v), 0);
    rdReg(5'h02, v);
    check(v == 8'h00, "R1 status", 64'(v), 0);
    check(spiCsN === 1'b1 && spiSck === 1'b0, "R1 bus idle",
          64'({spiCsN, spiSck}), 64'h2);
  endtask

  task automatic t_locked();
    int f0 = frames;
    logic [7:0] v;
    wrReg(5'h01, 8'd8);
    wrReg(5'h00, 8'h04);
    rdReg(5'h00, v);
    repeat (30) @(negedge clk);
    check(v == 8'h00 && frames == f0, "R2 locked ignores command",
          64'(frames - f0), 0);
  endtask

  task automatic t_full();
    int f0 = frames;
    logic [7:0] v;
    setPd(48'hAB12_3400_0000);
    wrReg(5'h01, 8'd48);
    slaveReply = 48'h1122_3344_5566;
    wrReg(5'h00, 8'h04);
    rdReg(5'h00, v);
    check(v == 8'h04, "R6 busy readback", 64'(v), 64'h04);
    waitIdle();
    check(frames == f0 + 1 && bitsSeen == 48, "R3 full frame length",
          64'(bitsSeen), 48);
    check(mosiLog[47:0] == 48'hAB12_3400_0000, "R3 mosi order",
          64'(mosiLog[47:0]), 64'hAB12_3400_0000);
    checkCaps(48'h1122_3344_5566, "R4 capture slots");
    check(csRise - lastFall == 20.0, "R8 cs hold", 64'(int'(csRise - lastFall)), 20);
  endtask

  task automatic t_short();
    setPd(48'h06C5_0000_0000);
    wrReg(5'h01, 8'd16);
    slaveReply = 48'hA55A_FFFF_FFFF;
    wrReg(5'h00, 8'h04);
    waitIdle();
    check(bitsSeen == 16 && mosiLog[15:0] == 16'h06C5, "R3 short frame",
          64'(mosiLog[15:0]), 64'h06C5);
    checkCaps(48'hA55A_0000_0000, "R4 cleared and partial capture");
  endtask

  task automatic t_zero();
    int f0 = frames;
    logic [7:0] v;
    wrReg(5'h01, 8'd0);
    wrReg(5'h00, 8'h04);
    repeat (10) @(negedge clk);
    rdReg(5'h00, v);
    check(v == 8'h00 && frames == f0, "R5 zero count no frame",
          64'(frames - f0), 0);
  endtask

  task automatic t_clamp();
    setPd(48'h0);
    wrReg(5'h01, 8'd60);
    slaveReply = 48'h0102_0304_0506;
    wrReg(5'h00, 8'h04);
    waitIdle();
    check(bitsSeen == 48, "R5 clamp to 48", 64'(bitsSeen), 48);
  endtask

  task automatic t_invalid();
    int f0 = frames;
    logic [7:0] v;
    wrReg(5'h00, 8'h08);
    repeat (20) @(negedge clk);
    rdReg(5'h00, v);
    check(v == 8'h00 && frames == f0, "R12 unknown command",
          64'(frames - f0), 0);
  endtask

  task automatic t_statRd();
    logic [7:0] v;
    slaveReply = 48'h00C3_0000_0000;
    wrReg(5'h00, 8'h02);
    waitIdle();
    check(bitsSeen == 16 && mosiLog[15:0] == 16'h0500, "R9 status read frame",
          64'(mosiLog[15:0]), 64'h0500);
    rdReg(5'h02, v);
    check(v == 8'hC3, "R9 status byte", 64'(v), 64'hC3);
    checkCaps(48'h0102_0304_0506, "R9 captures untouched");
  endtask

  task automatic t_statWr();
    wrReg(5'h0D, 8'h7C);
    wrReg(5'h00, 8'h20);
    waitIdle();
    check(bitsSeen == 16 && mosiLog[15:0] == 16'h017C, "R10 status write frame",
          64'(mosiLog[15:0]), 64'h017C);
  endtask

  task automatic t_collide();
    int f0 = frames;
    setPd(48'h9A00_0000_0000);
    wrReg(5'h01, 8'd8);
    wrReg(5'h00, 8'h04);
    repeat (3) @(negedge clk);
    wrReg(5'h0D, 8'h55);
    wrReg(5'h00, 8'h02);
    waitIdle();
    repeat (10) @(negedge clk);
    check(frames == f0 + 1 && bitsSeen == 8, "R11 command while busy",
          64'(frames - f0), 1);
    check(mosiLog[7:0] == 8'h9A, "R11 snapshot kept", 64'(mosiLog[7:0]), 64'h9A);
    wrReg(5'h00, 8'h04);
    waitIdle();
    check(mosiLog[7:0] == 8'h55, "R11 new byte next frame",
          64'(mosiLog[7:0]), 64'h55);
  endtask

  task automatic t_relock();
    int f0 = frames;
    wrReg(5'h03, 8'h00);
    wrReg(5'h00, 8'h04);
    repeat (30) @(negedge clk);
    check(frames == f0, "R2 relocked", 64'(frames - f0), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    wrReg(5'h03, 8'h30);
    t_full();
    t_short();
    t_zero();
    t_clamp();
    t_invalid();
    t_statRd();
    t_statWr();
    t_collide();
    t_relock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule